// File: doc/BRIEF.md
# Bit-Addressable Latch and Demultiplexer

This block keeps eight storage bits and drives eight active-low outputs. Each output is 1 when its channel is off. The caller picks how the block behaves with two active-low control inputs, `clr_n` and `en_n`. In addressable-latch mode, the bit named by a 3-bit address takes the value of a single data input and the other bits keep their values. In hold mode, everything is frozen. In decode mode, the block acts as a plain 3-to-8 demultiplexer and the stored bits are left alone. In clear mode, every output is forced off and the store is emptied.

Storage is built from registers on the system clock, and writes take effect only at a rising edge. The output path is combinational. While a write is pending, the addressed output already follows the data input, so the addressed channel responds within the same cycle. At the next edge the value is committed to the store. Software or a sequencer drives the control pins as plain levels, with no handshake.

Top module: `addr_latch_decoder`

## Requirements
- R1: The mode is decoded from the two control pins: `clr_n=1,en_n=0` is latch, `clr_n=1,en_n=1` is hold, `clr_n=0,en_n=0` is decode, and `clr_n=0,en_n=1` is clear.
- R2: In latch mode, output bit `q_n[addr]` equals `~din` in the same cycle. At the rising clock edge, `din` is stored into bit `addr`, so the output keeps that value after the block moves to hold mode.
- R3: In latch mode, every output other than `q_n[addr]` keeps its previous value, and the stored bits other than bit `addr` are unchanged by the edge.
- R4: In hold mode, every output equals the inverse of its stored bit, and `addr` and `din` have no effect on the outputs.
- R5: In decode mode, `q_n[addr]` equals `~din` and every other output is 1. The stored bits are not modified, which is visible when the block returns to hold mode.
- R6: In clear mode, all outputs are 1 whatever `addr` and `din` are. A rising edge in clear mode sets every stored bit to 0.
- R7: A synchronous active-low reset `rst_n` sets every stored bit to 0, so hold mode then shows all outputs at 1.
- R8: While `en_n` is 1, address and data changes across any number of clock edges never alter the stored bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; stored bits change on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the store |
| addr | input | 3 | Bit select, binary index 0..7 |
| din | input | 1 | Data bit to be stored or routed |
| clr_n | input | 1 | Active-low clear control (mode select, high bit) |
| en_n | input | 1 | Active-low enable control (mode select, low bit) |
| q_n | output | 8 | Active-low outputs; 1 means the channel is off |

## Verification
Some properties are checked on every clock cycle. Clear mode must force all ones. Decode mode must drive at most one output low, and that output must be the addressed one with `~din`. Hold mode must keep the outputs stable. A latch cycle followed by a hold cycle must show the committed bit and leave every other bit untouched. Clear and reset must both leave an all-ones hold view.

Other behaviour needs stimulus sequences that only the bench provides. Decode mode must leave the store intact. Repeated address and data toggling under hold must never leak into the store. The addressed output must follow `din` within the same latch cycle before the edge.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;

  // Operating modes derived from {clr_n, en_n}
  typedef enum logic [1:0] {
    MODE_DECODE = 2'b00,
    MODE_CLEAR  = 2'b01,
    MODE_LATCH  = 2'b10,
    MODE_HOLD   = 2'b11
  } alatch_mode_e;

endpackage

// File: rtl/addr_latch_mode_dec.sv
module addr_latch_mode_dec
  import addr_latch_pkg::*;
(
  input  logic         clr_n,
  input  logic         en_n,
  output alatch_mode_e mode
);

  // R1: two control pins pick one of four modes
  always_comb begin
    unique case ({clr_n, en_n})
      2'b10:   mode = MODE_LATCH;
      2'b11:   mode = MODE_HOLD;
      2'b00:   mode = MODE_DECODE;
      default: mode = MODE_CLEAR;
    endcase
  end

endmodule

// File: rtl/addr_latch_store.sv
module addr_latch_store
  import addr_latch_pkg::*;
#(
  parameter int NUM_BITS = 8,
  localparam int ADDR_W = $clog2(NUM_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  alatch_mode_e        mode,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                din,
  output logic [NUM_BITS-1:0] bits
);

  for (genvar i = 0; i < NUM_BITS; i++) begin : g_cell
    logic hit;
    assign hit = (addr == ADDR_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bits[i] <= 1'b0;                    // R7
      end else begin
        unique case (mode)
          MODE_LATCH:  if (hit) bits[i] <= din;  // R2, R3
          MODE_CLEAR:  bits[i] <= 1'b0;          // R6
          default:     bits[i] <= bits[i];       // R4, R5, R8
        endcase
      end
    end
  end

endmodule

// File: rtl/addr_latch_out_sel.sv
module addr_latch_out_sel
  import addr_latch_pkg::*;
#(
  parameter int NUM_BITS = 8,
  localparam int ADDR_W = $clog2(NUM_BITS)
) (
  input  alatch_mode_e        mode,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                din,
  input  logic [NUM_BITS-1:0] bits,
  output logic [NUM_BITS-1:0] q_n
);

  for (genvar i = 0; i < NUM_BITS; i++) begin : g_drv
    logic hit;
    assign hit = (addr == ADDR_W'(i));

    always_comb begin
      unique case (mode)
        MODE_LATCH:  q_n[i] = hit ? ~din : ~bits[i];  // transparent on addressed bit
        MODE_HOLD:   q_n[i] = ~bits[i];
        MODE_DECODE: q_n[i] = hit ? ~din : 1'b1;
        default:     q_n[i] = 1'b1;                    // clear
      endcase
    end
  end

endmodule

// File: rtl/addr_latch_decoder.sv
module addr_latch_decoder
  import addr_latch_pkg::*;
#(
  parameter int NUM_BITS = 8,
  localparam int ADDR_W = $clog2(NUM_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                din,
  input  logic                clr_n,
  input  logic                en_n,
  output logic [NUM_BITS-1:0] q_n
);

  alatch_mode_e        mode;
  logic [NUM_BITS-1:0] bits;

  addr_latch_mode_dec u_mode (
    .clr_n (clr_n),
    .en_n  (en_n),
    .mode  (mode)
  );

  addr_latch_store #(.NUM_BITS(NUM_BITS)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .mode  (mode),
    .addr  (addr),
    .din   (din),
    .bits  (bits)
  );

  addr_latch_out_sel #(.NUM_BITS(NUM_BITS)) u_out (
    .mode  (mode),
    .addr  (addr),
    .din   (din),
    .bits  (bits),
    .q_n   (q_n)
  );

endmodule

// File: rtl/addr_latch_decoder_chk.sv
module addr_latch_decoder_chk #(
  parameter int NUM_BITS = 8,
  localparam int ADDR_W = $clog2(NUM_BITS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   addr,
  input logic                din,
  input logic                clr_n,
  input logic                en_n,
  input logic [NUM_BITS-1:0] q_n
);

  logic is_latch, is_hold, is_dec, is_clr;
  assign is_latch = clr_n && !en_n;
  assign is_hold  = clr_n && en_n;
  assign is_dec   = !clr_n && !en_n;
  assign is_clr   = !clr_n && en_n;

  p_clear_all_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    is_clr |-> (q_n == '1));

  p_decode_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_dec |-> (($countones(~q_n) <= 1) && (q_n[addr] == !din)));

  p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_hold && $past(is_hold) && $past(rst_n)) |-> $stable(q_n));

  p_latch_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_hold && $past(is_latch) && $past(rst_n)) |-> (q_n[$past(addr)] == !$past(din)));

  p_latch_others_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_hold && $past(is_latch) && $past(rst_n)) |->
      (((q_n ^ $past(q_n)) & ~(NUM_BITS'(1) << $past(addr))) == '0));

  p_clear_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_hold && $past(is_clr) && $past(rst_n)) |-> (q_n == '1));

  p_reset_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_hold && !$past(rst_n)) |-> (q_n == '1));

endmodule

bind addr_latch_decoder addr_latch_decoder_chk #(.NUM_BITS(NUM_BITS)) u_chk (.*);

// File: tb/addr_latch_decoder_test.sv
module addr_latch_decoder_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       din = 1'b0;
  logic       clr_n = 1'b1;
  logic       en_n = 1'b1;
  logic [7:0] q_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;   // 50 MHz

  addr_latch_decoder uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
    .clr_n(clr_n), .en_n(en_n), .q_n(q_n)
  );

  // {req[3:0], clr_n, en_n, addr[2:0], din, expected q_n[7:0]}
  // Expected value is sampled before the rising edge that follows the vector.
  localparam logic [17:0] VEC [16] = '{
    {4'd4, 1'b1, 1'b1, 3'd0, 1'b0, 8'hFF},  // R4 hold after reset
    {4'd2, 1'b1, 1'b0, 3'd3, 1'b1, 8'hF7},  // R2 write 1 to bit 3
    {4'd2, 1'b1, 1'b0, 3'd0, 1'b1, 8'hF6},  // R2 write 1 to bit 0
    {4'd4, 1'b1, 1'b1, 3'd5, 1'b1, 8'hF6},  // R4 inputs ignored
    {4'd3, 1'b1, 1'b0, 3'd7, 1'b1, 8'h76},  // R3 others kept
    {4'd3, 1'b1, 1'b0, 3'd3, 1'b0, 8'h7E},  // R3 clear bit 3 only
    {4'd4, 1'b1, 1'b1, 3'd3, 1'b1, 8'h7E},  // R4
    {4'd5, 1'b0, 1'b0, 3'd2, 1'b1, 8'hFB},  // R5 decode low on bit 2
    {4'd5, 1'b0, 1'b0, 3'd6, 1'b0, 8'hFF},  // R5 decode din=0
    {4'd5, 1'b1, 1'b1, 3'd0, 1'b0, 8'h7E},  // R5 store untouched by decode
    {4'd6, 1'b0, 1'b1, 3'd4, 1'b1, 8'hFF},  // R6 clear forces all off
    {4'd6, 1'b1, 1'b1, 3'd7, 1'b1, 8'hFF},  // R6 store emptied
    {4'd2, 1'b1, 1'b0, 3'd6, 1'b1, 8'hBF},  // R2
    {4'd2, 1'b1, 1'b0, 3'd6, 1'b0, 8'hFF},  // R2 overwrite same bit
    {4'd1, 1'b1, 1'b0, 3'd1, 1'b1, 8'hFD},  // R1 latch decoded
    {4'd1, 1'b1, 1'b1, 3'd4, 1'b0, 8'hFD}   // R1 hold decoded
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: q_n=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic e, input logic [2:0] a, input logic d);
    @(negedge clk);
    clr_n = c; en_n = e; addr = a; din = d;
    #5;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: q_n=%h expected completion", q_n);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #5;
    check("R7 reset state", q_n, 8'hFF);

    // table walk
    for (int i = 0; i < 16; i++) begin
      drive(VEC[i][13], VEC[i][12], VEC[i][11:9], VEC[i][8]);
      check($sformatf("R%0d vector %0d", VEC[i][17:14], i), q_n, VEC[i][7:0]);
    end

    // R2: addressed output follows din within a latch cycle
    @(negedge clk);
    clr_n = 1'b1; en_n = 1'b0; addr = 3'd5; din = 1'b1;
    #2; check("R2 transparent din=1", q_n, 8'hDD);
    din = 1'b0;
    #2; check("R2 transparent din=0", q_n, 8'hFD);
    din = 1'b1;
    #2;
    drive(1'b1, 1'b1, 3'd0, 1'b0);
    check("R2 committed bit 5", q_n, 8'hDD);

    // R8: address/data activity under hold across many edges
    for (int k = 0; k < 24; k++) begin
      drive(1'b1, 1'b1, 3'(k), k[0]);
    end
    check("R8 store unchanged under hold", q_n, 8'hDD);

    // R6: clear with every address/data combination
    for (int k = 0; k < 16; k++) begin
      drive(1'b0, 1'b1, 3'(k), k[3]);
      check("R6 clear all off", q_n, 8'hFF);
    end
    drive(1'b1, 1'b1, 3'd2, 1'b1);
    check("R6 store empty after clear", q_n, 8'hFF);

    // R5: decode sweep leaves store intact
    drive(1'b1, 1'b0, 3'd4, 1'b1);
    drive(1'b1, 1'b1, 3'd0, 1'b0);
    check("R5 setup bit 4", q_n, 8'hEF);
    for (int k = 0; k < 8; k++) begin
      drive(1'b0, 1'b0, 3'(k), 1'b1);
      check("R5 decode sweep", q_n, ~(8'h01 << k));
    end
    drive(1'b1, 1'b1, 3'd7, 1'b1);
    check("R5 store intact after decode", q_n, 8'hEF);

    // R7: mid-run reset
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #5;
    check("R7 reset empties store", q_n, 8'hFF);

    done = 1;
    finish_run();
  end

endmodule